// File: doc/BRIEF.md
# Paged Segment Address Translator

This block turns a 32-bit virtual address into a physical address under a scheme that combines segments and paging. The two highest address bits pick one of four segments. Each segment has its own page table base and its own bound, loaded through a small register-write port. The next eighteen bits are a page index into that segment's table, and the twelve lowest bits are the byte offset within the page.

A request is accepted with a valid/ready handshake. The block first compares the page index with the segment bound. An index at or past the bound is reported as a fault at once, with no memory traffic. Otherwise the block reads one 4-byte page table entry from external memory over a read request/response handshake. It then tests the entry's present flag and reports either the physical address or a not-present fault, together with a single-cycle done pulse.

Top module: `pgseg_xlate`

## Requirements
- R1: A virtual address is split as segment = bits 31:30, page index = bits 29:12, offset = bits 11:0.
- R2: When `cfg_we` is high at a clock edge, `cfg_data` is written into segment `cfg_seg`. With `cfg_field` = 0 all 32 bits go to the page table base. With `cfg_field` = 1 bits 18:0 go to the bound. After reset every base and every bound is zero, so every translation faults on the bound.
- R3: If the page index is greater than or equal to the segment bound, `done` rises on the second clock edge after acceptance with `exc` = 1 (bound fault) and `paddr` = 0, and `mem_rd_valid` is never raised for that request.
- R4: For an index within the bound, the entry is read at address base + index*4 (modulo 2^32). `mem_rd_valid` stays high with a stable `mem_rd_addr` until `mem_rd_ready` is seen.
- R5: If bit 0 (present) of the returned entry is clear, the result is `exc` = 2 (not present) with `paddr` = 0.
- R6: If the present bit is set, the result is `exc` = 0 with `paddr` = {entry bits 31:12, offset}.
- R7: `req_ready` is high only while the block is idle. A request is taken on an edge where `req_valid` and `req_ready` are both high, and `req_ready` is low on the following cycle.
- R8: Each accepted request yields exactly one `done` pulse, one cycle wide. `exc` and `paddr` are valid while it is high, and `exc` never takes the value 3.
- R9: The segment's base and bound are captured when a request is accepted. Configuration writes made while that request is in flight affect only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_seg | input | 2 | Segment selected for the write |
| cfg_field | input | 1 | 0 = page table base, 1 = bound |
| cfg_data | input | 32 | Write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_rd_valid | output | 1 | Page table entry read request |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Page table entry returned |
| done | output | 1 | One-cycle result pulse |
| exc | output | 2 | 0 none, 1 bound fault, 2 not present |
| paddr | output | 32 | Physical address, 0 on a fault |

## Verification
A corrupted captured base shows up as a wrong `mem_rd_addr` on the first cycle of the read request. A corrupted bound or index shows up two cycles after acceptance, either as a missing or spurious bound fault or as a read request where none is allowed. A wrong controller state shows up as `req_ready` rising during a translation, as a second `done` pulse, or as a read request that changes address before it is taken. All of these are visible within a few cycles of the request. Bound checks are exercised at index = bound - 1, at index = bound, and at the largest bound, and one test writes configuration in mid-translation to show that the values captured at acceptance are the ones used.

// File: rtl/pgseg_pkg.sv
package pgseg_pkg;
  typedef enum logic [1:0] {
    XC_NONE   = 2'd0,
    XC_BOUND  = 2'd1,
    XC_ABSENT = 2'd2
  } xcode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_READ  = 2'd2,
    ST_WAIT  = 2'd3
  } xstate_e;
endpackage

// File: rtl/pgseg_regs.sv
module pgseg_regs #(
  parameter int SEG_W   = 2,
  parameter int ADDR_W  = 32,
  parameter int BOUND_W = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEG_W-1:0]   wr_seg,
  input  logic               wr_field,
  input  logic [ADDR_W-1:0]  wr_data,
  input  logic [SEG_W-1:0]   rd_seg,
  output logic [ADDR_W-1:0]  rd_base,
  output logic [BOUND_W-1:0] rd_bound
);
  localparam int SEGS = 1 << SEG_W;

  logic [ADDR_W-1:0]  base_q  [SEGS];
  logic [BOUND_W-1:0] bound_q [SEGS];
  logic [SEGS-1:0]    base_en;
  logic [SEGS-1:0]    bound_en;

  // per-segment write enables
  for (genvar g = 0; g < SEGS; g++) begin : g_we
    assign base_en[g]  = wr_en && (wr_seg == SEG_W'(g)) && !wr_field;
    assign bound_en[g] = wr_en && (wr_seg == SEG_W'(g)) &&  wr_field;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SEGS; i++) begin
        base_q[i]  <= '0;
        bound_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SEGS; i++) begin
        if (base_en[i])  base_q[i]  <= wr_data;
        if (bound_en[i]) bound_q[i] <= wr_data[BOUND_W-1:0];
      end
    end
  end

  assign rd_base  = base_q[rd_seg];
  assign rd_bound = bound_q[rd_seg];
endmodule

// File: rtl/pgseg_pte.sv
module pgseg_pte #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-OFF_W-1:0] frame_i,
  input  logic                    present_i,
  input  logic [OFF_W-1:0]        off_i,
  output logic                    present_o,
  output logic [ADDR_W-1:0]       phys_o
);
  assign present_o = present_i;
  assign phys_o    = {frame_i, off_i};
endmodule

// File: rtl/pgseg_ctrl.sv
module pgseg_ctrl
  import pgseg_pkg::*;
#(
  parameter int SEG_W  = 2,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int PTE_SH = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_vaddr,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         seg_base,
  input  logic [ADDR_W-SEG_W-OFF_W:0] seg_bound,
  output logic [OFF_W-1:0]          off_o,
  input  logic                      pte_present,
  input  logic [ADDR_W-1:0]         pte_phys,
  output logic                      mem_rd_valid,
  input  logic                      mem_rd_ready,
  output logic [ADDR_W-1:0]         mem_rd_addr,
  input  logic                      mem_rsp_valid,
  output logic                      done,
  output logic [1:0]                exc,
  output logic [ADDR_W-1:0]         paddr
);
  localparam int PIDX_W  = ADDR_W - SEG_W - OFF_W;
  localparam int BOUND_W = PIDX_W + 1;
  localparam int PAD_W   = ADDR_W - PIDX_W - PTE_SH;

  xstate_e             state_q, state_d;
  logic [ADDR_W-1:0]   base_q;
  logic [BOUND_W-1:0]  bound_q;
  logic [PIDX_W-1:0]   pidx_q;
  logic [OFF_W-1:0]    off_q;
  logic                done_q, done_d;
  xcode_e              exc_q, exc_d;
  logic [ADDR_W-1:0]   paddr_q, paddr_d;
  logic                cap_en;
  logic                in_bound;

  assign cap_en   = (state_q == ST_IDLE) && req_valid;
  assign in_bound = {1'b0, pidx_q} < bound_q;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    exc_d   = exc_q;
    paddr_d = paddr_q;
    case (state_q)
      ST_IDLE:  if (req_valid) state_d = ST_CHECK;
      ST_CHECK: begin
        if (in_bound) begin
          state_d = ST_READ;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          exc_d   = XC_BOUND;
          paddr_d = '0;
        end
      end
      ST_READ:  if (mem_rd_ready) state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          if (pte_present) begin
            exc_d   = XC_NONE;
            paddr_d = pte_phys;
          end else begin
            exc_d   = XC_ABSENT;
            paddr_d = '0;
          end
        end
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      base_q  <= '0;
      bound_q <= '0;
      pidx_q  <= '0;
      off_q   <= '0;
      exc_q   <= XC_NONE;
      paddr_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cap_en) begin
        base_q  <= seg_base;
        bound_q <= seg_bound;
        pidx_q  <= req_vaddr[OFF_W +: PIDX_W];
        off_q   <= req_vaddr[OFF_W-1:0];
      end
      if (done_d) begin
        exc_q   <= exc_d;
        paddr_q <= paddr_d;
      end
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_READ);
  assign mem_rd_addr  = base_q + {{PAD_W{1'b0}}, pidx_q, {PTE_SH{1'b0}}};
  assign off_o        = off_q;
  assign done         = done_q;
  assign exc          = exc_q;
  assign paddr        = paddr_q;
endmodule

// File: rtl/pgseg_xlate.sv
module pgseg_xlate #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 2,
  parameter int OFF_W  = 12,
  parameter int PTE_SH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEG_W-1:0]  cfg_seg,
  input  logic              cfg_field,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic [1:0]        exc,
  output logic [ADDR_W-1:0] paddr
);
  localparam int PIDX_W  = ADDR_W - SEG_W - OFF_W;
  localparam int BOUND_W = PIDX_W + 1;

  logic               rst_m, rst_s;
  logic [ADDR_W-1:0]  seg_base;
  logic [BOUND_W-1:0] seg_bound;
  logic [OFF_W-1:0]   off;
  logic               pte_present;
  logic [ADDR_W-1:0]  pte_phys;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  pgseg_regs #(.SEG_W(SEG_W), .ADDR_W(ADDR_W), .BOUND_W(BOUND_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr_en    (cfg_we),
    .wr_seg   (cfg_seg),
    .wr_field (cfg_field),
    .wr_data  (cfg_data),
    .rd_seg   (req_vaddr[ADDR_W-1 -: SEG_W]),
    .rd_base  (seg_base),
    .rd_bound (seg_bound)
  );

  pgseg_pte #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_pte (
    .frame_i   (mem_rsp_data[ADDR_W-1:OFF_W]),
    .present_i (mem_rsp_data[0]),
    .off_i     (off),
    .present_o (pte_present),
    .phys_o    (pte_phys)
  );

  pgseg_ctrl #(.SEG_W(SEG_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PTE_SH(PTE_SH)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_s),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_ready     (req_ready),
    .seg_base      (seg_base),
    .seg_bound     (seg_bound),
    .off_o         (off),
    .pte_present   (pte_present),
    .pte_phys      (pte_phys),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .exc           (exc),
    .paddr         (paddr)
  );
endmodule

// File: rtl/pgseg_xlate_chk.sv
module pgseg_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rsp_valid,
  input logic [ADDR_W-1:0] mem_rsp_data,
  input logic              done,
  input logic [1:0]        exc,
  input logic [ADDR_W-1:0] paddr
);
  logic              rd_seen;
  logic [ADDR_W-1:0] rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_seen <= 1'b0;
      rsp_q   <= '0;
    end else begin
      if (req_valid && req_ready)             rd_seen <= 1'b0;
      else if (mem_rd_valid && mem_rd_ready)  rd_seen <= 1'b1;
      if (mem_rsp_valid) rsp_q <= mem_rsp_data;
    end
  end

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R7
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R7
  no_read_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  exc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> exc != 2'd3);

  // R3
  bound_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && exc == 2'd1 |-> !rd_seen && paddr == '0);

  // R5
  absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && exc == 2'd2 |-> paddr == '0 && !rsp_q[0]);

  // R6
  frame_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && exc == 2'd0 |-> paddr[ADDR_W-1:12] == rsp_q[ADDR_W-1:12] && rsp_q[0]);
endmodule

bind pgseg_xlate pgseg_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_pgseg_xlate.sv
module tb_pgseg_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_field;
  logic [1:0]  cfg_seg;
  logic [31:0] cfg_data;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic        mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done;
  logic [1:0]  exc;
  logic [31:0] paddr;

  int checks = 0;
  int errors = 0;
  int n_reads = 0;
  int rdy_dly = 0;
  int rsp_dly = 0;
  logic [31:0] got_addr;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pgseg_xlate dut (.*);

  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [19:0] fr;
    fr = a[21:2] ^ 20'h3C5A1;
    return {fr, 11'd0, (a[4:2] != 3'b111)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // memory model
  initial begin
    mem_rd_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) begin
        n_reads++;
        got_addr = mem_rd_addr;
        repeat (rdy_dly) @(negedge clk);
        mem_rd_ready = 1;
        @(negedge clk);
        mem_rd_ready = 0;
        repeat (rsp_dly) @(negedge clk);
        mem_rsp_valid = 1;
        mem_rsp_data  = pte_of(got_addr);
        @(negedge clk);
        mem_rsp_valid = 0;
        mem_rsp_data  = '0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  task automatic cfg(input logic [1:0] s, input logic f, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_seg = s; cfg_field = f; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // runs one translation, returns result, reads made and cycles to done
  task automatic xlate(input logic [31:0] va, output logic [1:0] e, output logic [31:0] pa,
                       output int reads, output int cyc);
    int r0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 idle ready", {31'd0, req_ready}, 32'd1);
    r0 = n_reads;
    req_valid = 1; req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R7 busy after accept", {31'd0, req_ready}, 32'd0);
    cyc = 1;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R8 done seen", {31'd0, done}, 32'd1);
    e = exc; pa = paddr;
    reads = n_reads - r0;
    @(negedge clk);
    chk(done == 1'b0, "R8 single pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic expect_ok(input logic [31:0] va, input logic [31:0] base, input string tag);
    logic [1:0] e; logic [31:0] pa; int rd, cy;
    logic [31:0] ea, pte;
    xlate(va, e, pa, rd, cy);
    ea  = base + {10'd0, va[29:12], 2'b00};
    pte = pte_of(ea);
    chk(rd == 1, {tag, " R4 one read"}, rd, 1);
    chk(got_addr == ea, {tag, " R4 entry addr"}, got_addr, ea);
    if (pte[0]) begin
      chk(e == 2'd0, {tag, " R6 exc none"}, {30'd0, e}, 0);
      chk(pa == {pte[31:12], va[11:0]}, {tag, " R6 paddr"}, pa, {pte[31:12], va[11:0]});
    end else begin
      chk(e == 2'd2, {tag, " R5 exc absent"}, {30'd0, e}, 2);
      chk(pa == 32'd0, {tag, " R5 paddr zero"}, pa, 0);
    end
  endtask

  task automatic expect_bound(input logic [31:0] va, input string tag);
    logic [1:0] e; logic [31:0] pa; int rd, cy;
    xlate(va, e, pa, rd, cy);
    chk(e == 2'd1, {tag, " R3 exc bound"}, {30'd0, e}, 1);
    chk(pa == 32'd0, {tag, " R3 paddr zero"}, pa, 0);
    chk(rd == 0, {tag, " R3 no read"}, rd, 0);
    chk(cy == 2, {tag, " R3 latency"}, cy, 2);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R7 reset ready", {31'd0, req_ready}, 1);
    chk(done == 1'b0, "R8 reset done", {31'd0, done}, 0);
    chk(mem_rd_valid == 1'b0, "R4 reset no read", {31'd0, mem_rd_valid}, 0);
    expect_bound(32'h4000_0000, "R2 reset bound zero");
  endtask

  task automatic t_config();
    cfg(2'd0, 1'b0, 32'h0010_0000); cfg(2'd0, 1'b1, 32'd16);
    cfg(2'd1, 1'b0, 32'h0020_0000); cfg(2'd1, 1'b1, 32'h0004_0000);
    cfg(2'd2, 1'b0, 32'h8000_0000); cfg(2'd2, 1'b1, 32'hFFF8_0005);
    cfg(2'd3, 1'b0, 32'hFFFF_FFF0); cfg(2'd3, 1'b1, 32'd8);
  endtask

  task automatic t_main();
    expect_ok(32'h0000_3123, 32'h0010_0000, "R1 seg0 idx3");
    expect_ok(32'h4001_2ABC, 32'h0020_0000, "R1 seg1 idx0x12");
    expect_ok(32'h8000_2FFF, 32'h8000_0000, "R2 seg2 idx2");
    rdy_dly = 3; rsp_dly = 2;
    expect_ok(32'h0000_5001, 32'h0010_0000, "R4 slow memory");
    rdy_dly = 0; rsp_dly = 0;
  endtask

  task automatic t_bounds();
    expect_ok(32'h0000_F456, 32'h0010_0000, "R3 idx bound-1");
    expect_bound(32'h0001_0456, "R3 idx equal bound");
    expect_bound(32'h3FFF_F000, "R3 idx max");
    expect_ok(32'h7FFF_F010, 32'h0020_0000, "R3 full bound max idx");
    expect_bound(32'h8000_5000, "R2 bound low 19 bits");
  endtask

  task automatic t_absent();
    expect_ok(32'h0000_7010, 32'h0010_0000, "R5 absent seg0");
    expect_ok(32'hC000_6020, 32'hFFFF_FFF0, "R4 wraparound");
  endtask

  task automatic t_snapshot();
    logic [1:0] e; logic [31:0] pa; int rd, cy;
    logic [31:0] ea, pte;
    rdy_dly = 4;
    fork
      xlate(32'h8000_4321, e, pa, rd, cy);
      begin
        repeat (2) @(negedge clk);
        cfg(2'd2, 1'b1, 32'd0);
        cfg(2'd2, 1'b0, 32'h1234_0000);
      end
    join
    rdy_dly = 0;
    ea  = 32'h8000_0010;
    pte = pte_of(ea);
    chk(got_addr == ea, "R9 old base used", got_addr, ea);
    chk(e == 2'd0, "R9 old bound used", {30'd0, e}, 0);
    chk(pa == {pte[31:12], 12'h321}, "R9 paddr", pa, {pte[31:12], 12'h321});
    expect_bound(32'h8000_0000, "R9 new bound applies");
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_seg = 0; cfg_field = 0; cfg_data = 0;
    req_valid = 0; req_vaddr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_config();
    t_main();
    t_bounds();
    t_absent();
    t_snapshot();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule